// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is a purely combinational arithmetic logic unit. Two operands of a parameterised width (eight bits by default) and a four-bit operation code enter; a result of the same width and three status flags (zero, carry and negative) leave in the same cycle. It has no clock, no reset and no stored state, so it drops into a datapath between registers owned by the surrounding logic.

The supported operations are:

- addition and subtraction;
- the bitwise functions AND, OR, XOR and NOT;
- logical shifts left and right;
- a compare that reports flags only.

Subtraction adds the inverted second operand plus one, and reports a borrow on the carry flag.

Top module: `alu_core`

## Requirements
- R1: Opcode 0 (add) gives result = (op_a + op_b) mod 2^WIDTH, and flag_c equals the carry out of the top result bit.
- R2: Opcode 1 (subtract) gives result = (op_a - op_b) mod 2^WIDTH, and flag_c is 1 exactly when op_a < op_b (unsigned borrow).
- R3: Opcodes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands. Opcode 5 gives the bitwise inverse of op_a, and op_b has no effect on it.
- R4: Opcode 6 shifts op_a left and opcode 7 shifts it right, logically, by the unsigned value of op_b, filling with zeros. An amount of WIDTH or more gives zero.
- R5: Opcode 8 (compare) drives result to zero. flag_z, flag_n and flag_c are those of op_a - op_b, so equal operands give flag_z = 1.
- R6: For every opcode other than 8, flag_z is 1 exactly when result is zero, and flag_n equals result bit WIDTH-1.
- R7: For opcodes 2 to 7 and 9 to 15, flag_c is 0.
- R8: Opcodes 9 to 15 give a zero result, with flag_z = 1 and flag_n = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, also the shift amount |
| opcode | input | 4 | Operation select |
| result | output | WIDTH | Operation result |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry on add, borrow on subtract and compare |
| flag_n | output | 1 | Negative flag (top bit) |

## Verification
The assertions are immediate checks that evaluate whenever the inputs change. They assume that opcode and both operands carry known values, and they stay silent while any of them is unknown. The bench leaves every input undriven until it applies its first vector. From then on it always drives fully defined operands and opcodes, covering all sixteen codes, including the unused ones. Results are sampled half a clock period after each change, so the outputs have settled before they are compared.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OPCODE_W = 4;

    typedef enum logic [OPCODE_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_NOT = 4'd5,
        OP_SHL = 4'd6,
        OP_SHR = 4'd7,
        OP_CMP = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
    } alu_flags_t;

    // Operations that route through the adder and report carry/borrow
    function automatic logic uses_adder(input logic [OPCODE_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    endfunction

    // Operations that subtract (inverted operand plus one)
    function automatic logic uses_sub(input logic [OPCODE_W-1:0] op);
        return (op == OP_SUB) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cflag
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[WIDTH-1:0];
        // carry out on add; borrow is the inverse of carry on subtract
        cflag = sub ? ~wide[WIDTH] : wide[WIDTH];
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]    a,
    input  logic [WIDTH-1:0]    b,
    input  logic [OPCODE_W-1:0] op,
    output logic [WIDTH-1:0]    y
);
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] amt,
    input  logic             right,
    output logic [WIDTH-1:0] y
);
    localparam int SH_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [WIDTH:0] LIMIT = (WIDTH + 1)'(WIDTH);

    logic            too_far;
    logic [SH_W-1:0] sh;

    always_comb begin
        too_far = ({1'b0, amt} >= LIMIT);
        sh      = amt[SH_W-1:0];
        if (too_far)
            y = '0;
        else if (right)
            y = a >> sh;
        else
            y = a << sh;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]    op_a,
    input  logic [WIDTH-1:0]    op_b,
    input  logic [OPCODE_W-1:0] opcode,
    output logic [WIDTH-1:0]    result,
    output logic                flag_z,
    output logic                flag_c,
    output logic                flag_n
);
    logic [WIDTH-1:0] arith_y;
    logic             arith_c;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] shift_y;
    logic [WIDTH-1:0] flag_src;
    alu_flags_t       flags;

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a     (op_a),
        .b     (op_b),
        .sub   (uses_sub(opcode)),
        .sum   (arith_y),
        .cflag (arith_c)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .op (opcode),
        .y  (logic_y)
    );

    alu_shift #(.WIDTH(WIDTH)) u_shift (
        .a     (op_a),
        .amt   (op_b),
        .right (opcode == OP_SHR),
        .y     (shift_y)
    );

    always_comb begin
        case (opcode)
            OP_ADD, OP_SUB:                 result = arith_y;
            OP_AND, OP_OR, OP_XOR, OP_NOT:  result = logic_y;
            OP_SHL, OP_SHR:                 result = shift_y;
            default:                        result = '0;
        endcase

        // compare takes its flags from the difference, not the result
        flag_src = (opcode == OP_CMP) ? arith_y : result;
        flags.z  = (flag_src == '0);
        flags.n  = flag_src[WIDTH-1];
        flags.c  = uses_adder(opcode) ? arith_c : 1'b0;

        flag_z = flags.z;
        flag_c = flags.c;
        flag_n = flags.n;
    end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0]    op_a,
    input logic [WIDTH-1:0]    op_b,
    input logic [OPCODE_W-1:0] opcode,
    input logic [WIDTH-1:0]    result,
    input logic                flag_z,
    input logic                flag_c,
    input logic                flag_n
);
    logic known;
    logic [WIDTH:0] add_wide;

    always_comb begin
        known    = !$isunknown({op_a, op_b, opcode});
        add_wide = {1'b0, op_a} + {1'b0, op_b};
        if (known) begin
            if (opcode == 4'd0)
                a_r1_add_carry: assert (flag_c == add_wide[WIDTH])
                    else $error("add carry mismatch");
            if (opcode == 4'd1)
                a_r2_sub_borrow: assert (flag_c == (op_a < op_b))
                    else $error("subtract borrow mismatch");
            if (opcode == 4'd8)
                a_r5_cmp_equal: assert ((flag_z == (op_a == op_b)) && (result == '0))
                    else $error("compare flag or result wrong");
            if (opcode != 4'd8)
                a_r6_zero_neg: assert ((flag_z == (result == '0)) && (flag_n == result[WIDTH-1]))
                    else $error("zero or negative flag disagrees with result");
            if (opcode >= 4'd9)
                a_r8_unused_zero: assert (result == '0)
                    else $error("unused opcode produced data");
            if ((opcode >= 4'd2 && opcode <= 4'd7) || opcode >= 4'd9)
                a_r7_carry_clear: assert (!flag_c)
                    else $error("carry set on non-arithmetic opcode");
        end
    end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a   (op_a),
    .op_b   (op_b),
    .opcode (opcode),
    .result (result),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_n (flag_n)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] res;
        logic         z;
        logic         c;
        logic         n;
        logic [3:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [3:0]   opcode;
    logic [W-1:0] result;
    logic         flag_z, flag_c, flag_n;

    int    n_vec = 0;
    int    n_bad = 0;
    exp_t  q_exp[$];
    string q_tag[$];
    logic  done = 1'b0;

    always #5 clk = ~clk;

    alu_core #(.WIDTH(W)) dut (
        .op_a   (op_a),
        .op_b   (op_b),
        .opcode (opcode),
        .result (result),
        .flag_z (flag_z),
        .flag_c (flag_c),
        .flag_n (flag_n)
    );

    // independent reference derived from the requirements
    function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        logic [W:0] s;
        e.op = op; e.a = a; e.b = b; e.c = 1'b0;
        case (op)
            4'd0: begin s = {1'b0, a} + {1'b0, b}; e.res = s[W-1:0]; e.c = s[W]; end
            4'd1: begin e.res = a - b; e.c = (a < b); end
            4'd2: e.res = a & b;
            4'd3: e.res = a | b;
            4'd4: e.res = a ^ b;
            4'd5: e.res = ~a;
            4'd6: e.res = (b >= W) ? '0 : (a << b);
            4'd7: e.res = (b >= W) ? '0 : (a >> b);
            4'd8: begin e.res = '0; e.c = (a < b); end
            default: e.res = '0;
        endcase
        if (op == 4'd8) begin
            s   = {1'b0, a - b};
            e.z = (a == b);
            e.n = s[W-1];
        end else begin
            e.z = (e.res == '0);
            e.n = e.res[W-1];
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1 R6";
            4'd1: return "R2 R6";
            4'd2, 4'd3, 4'd4, 4'd5: return "R3 R6 R7";
            4'd6, 4'd7: return "R4 R6 R7";
            4'd8: return "R5";
            default: return "R8 R6 R7";
        endcase
    endfunction

    // driver: applies a vector at the falling edge and queues its expectation
    task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_a = a; op_b = b; opcode = op;
        q_exp.push_back(model(op, a, b));
        q_tag.push_back(tag_of(op));
    endtask

    // monitor: outputs settled for half a period when the rising edge comes
    always @(posedge clk) begin
        if (!rst && q_exp.size() > 0) begin
            exp_t e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_vec++;
            if (result !== e.res || flag_z !== e.z || flag_c !== e.c || flag_n !== e.n) begin
                n_bad++;
                $display("FAIL %s op=%0d a=%h b=%h: got res=%h z=%b c=%b n=%b, expected res=%h z=%b c=%b n=%b",
                         t, e.op, e.a, e.b, result, flag_z, flag_c, flag_n, e.res, e.z, e.c, e.n);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R6: all-zero inputs, add of zeros gives zero with Z set
        apply(4'd0, 8'h00, 8'h00);
        // R1: plain add and carry out
        apply(4'd0, 8'h45, 8'h23);
        apply(4'd0, 8'hFF, 8'h01);
        apply(4'd0, 8'h80, 8'h80);
        // R2: borrow and no borrow
        apply(4'd1, 8'h45, 8'h23);
        apply(4'd1, 8'h23, 8'h45);
        apply(4'd1, 8'h77, 8'h77);
        apply(4'd1, 8'h00, 8'hFF);
        // R3: bitwise, NOT ignores op_b
        apply(4'd2, 8'hFF, 8'h0F);
        apply(4'd3, 8'hA0, 8'h05);
        apply(4'd4, 8'hAA, 8'hAA);
        apply(4'd5, 8'h0F, 8'h00);
        apply(4'd5, 8'h0F, 8'hFF);
        // R4: shifts incl. boundary amounts
        apply(4'd6, 8'h01, 8'h03);
        apply(4'd6, 8'h81, 8'h07);
        apply(4'd6, 8'hFF, 8'h08);
        apply(4'd7, 8'h80, 8'h07);
        apply(4'd7, 8'hFF, 8'hFF);
        apply(4'd7, 8'h5A, 8'h00);
        // R5: compare equal, smaller, larger
        apply(4'd8, 8'h45, 8'h45);
        apply(4'd8, 8'h23, 8'h45);
        apply(4'd8, 8'h45, 8'h23);
        // R8: every unused opcode
        for (int k = 9; k < 16; k++) apply(4'(k), 8'hC3, 8'h3C);
        // random sweep over all opcodes
        for (int i = 0; i < 600; i++)
            apply(4'($urandom_range(15, 0)), W'($urandom), W'($urandom));
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule